// File: doc/BRIEF.md
# Radio Mode Sequencer

This controller steps a transceiver through its power and activity modes. It starts in a low-power sleep mode, moves through a waiting mode into a ready (alert) mode, and from there enters receive, transmit or full-duplex operation. When activity ends, it leaves through a short end-of-burst mode and returns to either the ready mode or the waiting mode. The waiting mode and the end-of-burst modes advance on their own after a programmable number of clock cycles.

Activity can be commanded from one of two sources, chosen by a mode input. The first source is a register bit that forces transmission. The second is a pair of pins, an enable pin and a direction pin, sampled on the block clock. The enable pin can be read as a level or as a series of pulses. In time-division (TDD) operation the direction pin picks receive or transmit. In frequency-division (FDD) operation both paths run at once and the direction pin plays no part.

The block outputs a 4-bit mode code on every cycle, together with power-up requests for the receive and transmit synthesizers. The control inputs are plain static configuration levels, so the block has no streaming interface.

Top module: `radio_mode_sequencer`

## Requirements
- R1: While `rst_n` is low, and right after it is asserted at any time (asynchronously), `state_code` is 0 (SLEEP) and both synthesizer requests are low.
- R2: SLEEP moves to WAIT (code 1) at the clock edge after `clocks_on` is seen high. WAIT falls back to SLEEP if `clocks_on` is low. Pin activity in SLEEP has no effect on `state_code`.
- R3: WAIT lasts `dwell_cycles`+1 cycles while `clocks_on` stays high, and then moves to ALERT (code 5).
- R4: With `pin_ctrl`=1 and `pulse_mode`=0, an `enable_pin` level of 1 seen in ALERT starts activity, and a level of 0 during activity ends it. A pin change sampled at edge k takes effect in `state_code` at edge k+1.
- R5: With `pin_ctrl`=1 and `pulse_mode`=1, a rising edge on `enable_pin` starts activity in ALERT, and the next rising edge ends it. A high of one clock cycle counts as a pulse.
- R6: When activity starts in TDD (`fdd_mode`=0), the sampled `txnrx_pin` selects the mode: 1 gives TX (code 6) and 0 gives RX (code 8). With `fdd_mode`=1 the mode is FDD (code 10) whatever the direction pin shows.
- R7: With `pin_ctrl`=0, `force_tx`=1 in ALERT moves to TX (or to FDD if `fdd_mode`=1) at the next edge, and `force_tx`=0 ends the activity. In this mode the pins have no effect.
- R8: When activity ends, the machine enters an end-of-burst mode: 7 after TX, 9 after RX, 11 after FDD. This mode lasts `dwell_cycles`+1 cycles and then moves to WAIT if `return_to_wait`=1, or to ALERT if it is 0.
- R9: Synthesizer requests follow the mode. Both are low in SLEEP and WAIT. Both are high in ALERT, FDD and the FDD end-of-burst mode. Only the transmit request is high in 6 and 7. Only the receive request is high in 8 and 9.
- R10: `state_code` only ever takes one of the values 0, 1, 5, 6, 7, 8, 9, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the pin sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clocks_on | input | 1 | Handshake: the radio clocks are running |
| pin_ctrl | input | 1 | 1 selects pin control, 0 selects register control |
| pulse_mode | input | 1 | 1 reads the enable pin as pulses, 0 reads it as a level |
| fdd_mode | input | 1 | 1 selects full-duplex operation, 0 selects TDD |
| return_to_wait | input | 1 | 1 makes end of activity return to WAIT, 0 returns to ALERT |
| force_tx | input | 1 | Register bit that forces transmit activity |
| dwell_cycles | input | DWELL_W | Dwell length of the self-advancing modes, minus one |
| enable_pin | input | 1 | Activity enable pin |
| txnrx_pin | input | 1 | Direction pin (1 = transmit) |
| state_code | output | 4 | Current mode code |
| rx_synth_en | output | 1 | Receive synthesizer power-up request |
| tx_synth_en | output | 1 | Transmit synthesizer power-up request |

## Verification
The assertions assume that the configuration inputs (`pin_ctrl`, `pulse_mode`, `fdd_mode`, `return_to_wait`, `dwell_cycles`) are valid at every clock edge. They accept changes to these inputs at any time, because every property is written only in terms of the current mode and the inputs at that edge. The stimulus changes the configuration mostly in ALERT or after an end-of-burst mode has finished. It drives all inputs half a cycle away from the active edge, so no change coincides with sampling. Pin pulses are made as short as one cycle, and the dwell value is set to zero as well as larger values, so that both the shortest pulses and the shortest self-advancing modes are exercised.

// File: rtl/rms_pkg.sv
package rms_pkg;
  typedef enum logic [3:0] {
    ST_SLEEP   = 4'd0,
    ST_WAIT    = 4'd1,
    ST_ALERT   = 4'd5,
    ST_TX      = 4'd6,
    ST_TX_END  = 4'd7,
    ST_RX      = 4'd8,
    ST_RX_END  = 4'd9,
    ST_FDD     = 4'd10,
    ST_FDD_END = 4'd11
  } rms_state_e;

  function automatic logic is_active(rms_state_e s);
    return (s == ST_TX) || (s == ST_RX) || (s == ST_FDD);
  endfunction
endpackage

// File: rtl/rms_pin_capture.sv
module rms_pin_capture #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pin,
  input  logic dir_pin,
  output logic en_lvl,
  output logic en_rise,
  output logic dir_lvl
);
  logic [STAGES-1:0] en_sh;
  logic [STAGES-1:0] dir_sh;
  logic              en_prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_sh[g]  <= 1'b0;
          dir_sh[g] <= 1'b0;
        end else if (g == 0) begin
          en_sh[g]  <= en_pin;
          dir_sh[g] <= dir_pin;
        end else begin
          en_sh[g]  <= en_sh[(g == 0) ? 0 : g-1];
          dir_sh[g] <= dir_sh[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev <= 1'b0;
    else        en_prev <= en_sh[STAGES-1];
  end

  assign en_lvl  = en_sh[STAGES-1];
  assign dir_lvl = dir_sh[STAGES-1];
  assign en_rise = en_sh[STAGES-1] & ~en_prev;
endmodule

// File: rtl/rms_dwell_timer.sv
module rms_dwell_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] dwell,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (~&cnt)   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= dwell);
endmodule

// File: rtl/rms_synth_decode.sv
module rms_synth_decode
  import rms_pkg::*;
(
  input  rms_state_e st,
  output logic       rx_en,
  output logic       tx_en
);
  always_comb begin
    rx_en = 1'b0;
    tx_en = 1'b0;
    unique case (st)
      ST_ALERT, ST_FDD, ST_FDD_END: begin rx_en = 1'b1; tx_en = 1'b1; end
      ST_TX, ST_TX_END:             tx_en = 1'b1;
      ST_RX, ST_RX_END:             rx_en = 1'b1;
      default:                      ;
    endcase
  end
endmodule

// File: rtl/radio_mode_sequencer.sv
module radio_mode_sequencer
  import rms_pkg::*;
#(
  parameter int DWELL_W     = 8,
  parameter int PIN_STAGES  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clocks_on,
  input  logic               pin_ctrl,
  input  logic               pulse_mode,
  input  logic               fdd_mode,
  input  logic               return_to_wait,
  input  logic               force_tx,
  input  logic [DWELL_W-1:0] dwell_cycles,
  input  logic               enable_pin,
  input  logic               txnrx_pin,
  output logic [3:0]         state_code,
  output logic               rx_synth_en,
  output logic               tx_synth_en
);
  rms_state_e st_q, st_d;
  logic en_lvl, en_rise, dir_lvl, dwell_done;
  logic start_req, stop_req;
  rms_state_e start_tgt;

  rms_pin_capture #(.STAGES(PIN_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .en_pin(enable_pin), .dir_pin(txnrx_pin),
    .en_lvl(en_lvl), .en_rise(en_rise), .dir_lvl(dir_lvl)
  );

  rms_dwell_timer #(.W(DWELL_W)) u_dwell (
    .clk(clk), .rst_n(rst_n), .restart(st_d != st_q),
    .dwell(dwell_cycles), .expired(dwell_done)
  );

  always_comb begin
    if (pin_ctrl) begin
      start_req = pulse_mode ? en_rise : en_lvl;
      stop_req  = pulse_mode ? en_rise : ~en_lvl;
      start_tgt = fdd_mode ? ST_FDD : (dir_lvl ? ST_TX : ST_RX);
    end else begin
      start_req = force_tx;
      stop_req  = ~force_tx;
      start_tgt = fdd_mode ? ST_FDD : ST_TX;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_SLEEP: if (clocks_on) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!clocks_on)      st_d = ST_SLEEP;
        else if (dwell_done) st_d = ST_ALERT;
      end
      ST_ALERT: if (start_req) st_d = start_tgt;
      ST_TX:    if (stop_req) st_d = ST_TX_END;
      ST_RX:    if (stop_req) st_d = ST_RX_END;
      ST_FDD:   if (stop_req) st_d = ST_FDD_END;
      ST_TX_END, ST_RX_END, ST_FDD_END:
        if (dwell_done) st_d = return_to_wait ? ST_WAIT : ST_ALERT;
      default:  st_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_SLEEP;
    else        st_q <= st_d;
  end

  rms_synth_decode u_synth (.st(st_q), .rx_en(rx_synth_en), .tx_en(tx_synth_en));

  assign state_code = st_q;
endmodule

// File: rtl/rms_checker.sv
module rms_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       clocks_on,
  input logic       pin_ctrl,
  input logic       fdd_mode,
  input logic       force_tx,
  input logic [3:0] state_code,
  input logic       rx_synth_en,
  input logic       tx_synth_en
);
  assert_sleep_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd0 && !clocks_on) |=> (state_code == 4'd0));

  assert_sleep_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd0) |=> (state_code == 4'd0 || state_code == 4'd1));

  assert_alert_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd5 && $past(state_code) != 4'd5) |->
      ($past(state_code) inside {4'd1, 4'd7, 4'd9, 4'd11}));

  assert_fdd_no_tdd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd5 && fdd_mode) |=> (state_code != 4'd6 && state_code != 4'd8));

  assert_reg_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd5 && !pin_ctrl && !force_tx) |=> (state_code == 4'd5));

  assert_end_follows_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code inside {4'd7, 4'd9, 4'd11} && $past(state_code) != state_code) |->
      ($past(state_code) == state_code - 4'd1));

  assert_tdd_tx_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code inside {4'd6, 4'd7}) |-> (tx_synth_en && !rx_synth_en));

  assert_tdd_rx_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code inside {4'd8, 4'd9}) |-> (rx_synth_en && !tx_synth_en));

  assert_legal_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state_code inside {4'd0, 4'd1, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11});
endmodule

bind radio_mode_sequencer rms_checker i_rms_checker (
  .clk(clk), .rst_n(rst_n), .clocks_on(clocks_on), .pin_ctrl(pin_ctrl),
  .fdd_mode(fdd_mode), .force_tx(force_tx), .state_code(state_code),
  .rx_synth_en(rx_synth_en), .tx_synth_en(tx_synth_en)
);

// File: tb/test_radio_mode_sequencer.sv
`timescale 1ns/1ps
module test_radio_mode_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clocks_on = 0, pin_ctrl = 0, pulse_mode = 0, fdd_mode = 0;
  logic return_to_wait = 0, force_tx = 0, enable_pin = 0, txnrx_pin = 0;
  logic [7:0] dwell_cycles = 8'd3;
  logic [3:0] state_code;
  logic rx_synth_en, tx_synth_en;

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  radio_mode_sequencer i_radio_mode_sequencer (
    .clk(clk), .rst_n(rst_n), .clocks_on(clocks_on), .pin_ctrl(pin_ctrl),
    .pulse_mode(pulse_mode), .fdd_mode(fdd_mode), .return_to_wait(return_to_wait),
    .force_tx(force_tx), .dwell_cycles(dwell_cycles), .enable_pin(enable_pin),
    .txnrx_pin(txnrx_pin), .state_code(state_code), .rx_synth_en(rx_synth_en),
    .tx_synth_en(tx_synth_en)
  );

  // Behavioural reference model
  int m_st = 0, m_cnt = 0;
  bit m_en1 = 0, m_en2 = 0, m_dir = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_en1 = 0; m_en2 = 0; m_dir = 0;
    end else begin
      bit rise, start, stop;
      int tgt, nx;
      rise  = m_en1 && !m_en2;
      start = pin_ctrl ? (pulse_mode ? rise : m_en1) : force_tx;
      stop  = pin_ctrl ? (pulse_mode ? rise : !m_en1) : !force_tx;
      if (fdd_mode) tgt = 10;
      else if (pin_ctrl) tgt = m_dir ? 6 : 8;
      else tgt = 6;
      nx = m_st;
      if (m_st == 0) begin
        if (clocks_on) nx = 1;
      end else if (m_st == 1) begin
        if (!clocks_on) nx = 0;
        else if (m_cnt >= dwell_cycles) nx = 5;
      end else if (m_st == 5) begin
        if (start) nx = tgt;
      end else if (m_st == 6 || m_st == 8 || m_st == 10) begin
        if (stop) nx = m_st + 1;
      end else begin
        if (m_cnt >= dwell_cycles) nx = return_to_wait ? 1 : 5;
      end
      if (nx != m_st) m_cnt = 0;
      else if (m_cnt < 255) m_cnt++;
      m_st = nx;
      m_en2 = m_en1; m_en1 = enable_pin; m_dir = txnrx_pin;
    end
  end

  function automatic void exp_synth(int s, output bit rx, output bit tx);
    rx = (s == 5 || s == 10 || s == 11 || s == 8 || s == 9);
    tx = (s == 5 || s == 10 || s == 11 || s == 6 || s == 7);
  endfunction

  task automatic compare();
    bit erx, etx;
    exp_synth(m_st, erx, etx);
    checks++;
    if (state_code !== 4'(m_st) || rx_synth_en !== erx || tx_synth_en !== etx) begin
      fails++;
      $display("FAIL %s: state/rx/tx actual %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, state_code, rx_synth_en, tx_synth_en, m_st, erx, etx);
    end
  endtask

  always @(negedge clk) if (rst_n) compare();

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    enable_pin = 1; tick(1); enable_pin = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    // R1: reset state
    checks++;
    if (state_code !== 4'd0 || rx_synth_en !== 1'b0 || tx_synth_en !== 1'b0) begin
      fails++;
      $display("FAIL R1: actual %0d/%0b/%0b expected 0/0/0", state_code, rx_synth_en, tx_synth_en);
    end
    rst_n = 1;
    tag = "R2"; pin_ctrl = 1; pulse_mode = 1;
    pulse(); tick(3); enable_pin = 1; tick(3); enable_pin = 0; tick(2);
    clocks_on = 1; tick(2); clocks_on = 0; tick(3); clocks_on = 1;
    tag = "R3 R10"; tick(8);
    tag = "R4 R6 R9"; pulse_mode = 0; txnrx_pin = 0; enable_pin = 1; tick(10);
    enable_pin = 0; tick(8);
    txnrx_pin = 1; enable_pin = 1; tick(6); enable_pin = 0; tick(8);
    tag = "R6 R9"; fdd_mode = 1; enable_pin = 1;
    for (int i = 0; i < 6; i++) begin txnrx_pin = ~txnrx_pin; tick(1); end
    enable_pin = 0; tick(8); fdd_mode = 0;
    tag = "R5"; pulse_mode = 1; txnrx_pin = 1;
    pulse(); tick(6); pulse(); tick(8);
    txnrx_pin = 0; pulse(); tick(5); pulse(); tick(8);
    tag = "R7"; pin_ctrl = 0; force_tx = 1;
    for (int i = 0; i < 6; i++) begin enable_pin = ~enable_pin; tick(1); end
    enable_pin = 0; force_tx = 0; pulse(); tick(8);
    fdd_mode = 1; force_tx = 1; tick(4); force_tx = 0; tick(8); fdd_mode = 0;
    tag = "R8"; return_to_wait = 1; pin_ctrl = 1; pulse_mode = 0;
    enable_pin = 1; tick(5); enable_pin = 0; tick(12);
    dwell_cycles = 8'd0; enable_pin = 1; tick(3); enable_pin = 0; tick(5);
    return_to_wait = 0; enable_pin = 1; tick(3); enable_pin = 0; tick(4);
    tag = "R1"; dwell_cycles = 8'd2; enable_pin = 1; tick(4);
    #2 rst_n = 0; #1;
    checks++;
    if (state_code !== 4'd0 || rx_synth_en !== 1'b0 || tx_synth_en !== 1'b0) begin
      fails++;
      $display("FAIL R1: async actual %0d/%0b/%0b expected 0/0/0", state_code, rx_synth_en, tx_synth_en);
    end
    enable_pin = 0; tick(2); rst_n = 1; tick(10);
    finish_run();
  end
endmodule